// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures an external signal in one of three ways. With the high-frequency input selected, it counts every second rising edge of that input during a gate window timed in reference ticks. With the low-frequency input selected, it either counts that input's rising edges during the same kind of gate window, or it counts reference ticks across one or two full periods of the input. Both inputs arrive asynchronously. Each goes through a two-flop synchronizer, and only rising edges count.

A controller sets the mode inputs and pulses `start`. `busy` stays high while the window is open. When the window closes, `done` pulses for one clock and the result appears on `count`. The controller then clocks the result out most significant bit first on `sdo`, one `shift_step` pulse per bit. If `integrate` is set when a measurement is started, the new measurement adds to the previous result instead of clearing it. The counter saturates at all-ones and raises an overflow flag. When `meter_en` is low, the block accepts no measurements and `sdo` reports the synchronized level of the selected input.

Top module: `sigmeter`

## Requirements
- R1: After reset, `count` is 0 and `busy`, `done`, `overflow` and `sdo` are 0.
- R2: High-frequency frequency mode is selected by `sel_hf`=1. It counts the 1st, 3rd, 5th and later rising edges of `hf_in` after `start`, which is a divide-by-2 prescale restarted by each start. A gate holding n edges yields ceil(n/2).
- R3: Low-frequency frequency mode is selected by `sel_hf`=0 and `freq_mode`=1. It counts every rising edge of `lf_in` inside the gate. Falling edges and steady levels add nothing.
- R4: In both frequency modes, `busy` is high for exactly G reference ticks, counting only ticks sampled while `busy` is high. G = M × TICKS_PER_MS, where `gate_sel` values 0, 1, 2 and 3 give M = 4, 8, 32 and 64.
- R5: Period mode is selected by `sel_hf`=0 and `freq_mode`=0. The block waits for a first rising edge of `lf_in`, then counts reference ticks until one further rising edge (`two_period`=0) or two further rising edges (`two_period`=1).
- R6: A start with `integrate`=0 clears `count` and `overflow`, and the cleared value is visible while `busy` is high. A start with `integrate`=1 keeps both and adds the new measurement. While `busy` is low and no start is accepted, `count` does not change.
- R7: `done` is high for one clock, in the first cycle in which `busy` is low after a window. A `start` that arrives while `busy` is high is ignored and does not restart or clear the window.
- R8: When an increment is due while `count` is all-ones, `count` holds at all-ones and `overflow` rises. `overflow` stays high until a non-integrating start.
- R9: With `meter_en`=1, from the second cycle after `done`, `sdo` carries the result MSB first. Each `shift_step` pulse moves `sdo` to the next lower bit, and zeros follow the LSB.
- R10: With `meter_en`=0, `start` is ignored and `busy` stays low. `sdo` shows the level of `hf_in` (when `sel_hf`=1) or `lf_in` (when `sel_hf`=0), delayed by two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hf_in | input | 1 | High-frequency signal, asynchronous |
| lf_in | input | 1 | Low-frequency signal, asynchronous |
| ref_tick | input | 1 | One-clock reference tick pulse |
| meter_en | input | 1 | 1: counter active; 0: pin level on `sdo` |
| sel_hf | input | 1 | 1: high-frequency input; 0: low-frequency input |
| freq_mode | input | 1 | With `sel_hf`=0: 1 frequency, 0 period |
| two_period | input | 1 | Period window of two input periods |
| integrate | input | 1 | Keep the previous result at start |
| gate_sel | input | 2 | Gate length select (4/8/32/64 ms) |
| start | input | 1 | Start pulse |
| shift_step | input | 1 | Serial readout step pulse |
| count | output | CNT_W | Measurement result |
| overflow | output | 1 | Saturation flag |
| busy | output | 1 | Window open |
| done | output | 1 | One-clock end-of-window pulse |
| sdo | output | 1 | Serial result or pin level |

## Verification
The bench checks that the prescaler gives ceil(n/2) for odd edge counts. A design that did not restart the divider at each start would be off by one on alternate runs. It counts the reference ticks seen while `busy` is high and requires the exact gate length, which exposes an off-by-one in the gate terminal count. It drives period windows whose length is an exact multiple of the tick spacing, so that a missed arming edge, or a wrong count of one versus two periods, shows as a wrong multiple. It also checks that a period run longer than the counter range pins at all-ones with `overflow` set, that a mid-window restart is ignored, that integrating starts add to the held value, and that the serial stream reproduces `count` and then carries zeros.

// File: rtl/sigmeter_pkg.sv
package sigmeter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_MEAS
    } meas_state_e;

    typedef enum logic [1:0] {
        MD_HF_FREQ,
        MD_LF_FREQ,
        MD_LF_PERIOD
    } meas_mode_e;

    // Gate length in milliseconds for each select code
    function automatic int unsigned gate_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 8;
            2'd2:    return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/sigmeter_sync.sv
module sigmeter_sync #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] pin_i,
    output logic [NUM-1:0] level_o,
    output logic [NUM-1:0] rise_o
);

    typedef struct packed {
        logic [NUM-1:0] s1;
        logic [NUM-1:0] s2;
        logic [NUM-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // one edge detector per input
    for (genvar g = 0; g < NUM; g++) begin : g_edge
        assign level_o[g] = sync_q.s2[g];
        assign rise_o[g]  = sync_q.s2[g] & ~sync_q.s3[g];
    end

endmodule

// File: rtl/sigmeter_ctrl.sv
module sigmeter_ctrl
    import sigmeter_pkg::*;
#(
    parameter int TICKS_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       en_i,
    input  logic       sel_hf_i,
    input  logic       freq_mode_i,
    input  logic       two_period_i,
    input  logic       integrate_i,
    input  logic [1:0] gate_sel_i,
    input  logic       hf_rise_i,
    input  logic       lf_rise_i,
    input  logic       ref_tick_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       clr_o,
    output logic       inc_o
);

    localparam int MAX_GATE = 64 * TICKS_PER_MS;
    localparam int TICK_W   = (MAX_GATE > 1) ? $clog2(MAX_GATE) : 1;

    typedef struct packed {
        meas_state_e       state;
        meas_mode_e        mode;
        logic              two_per;
        logic [TICK_W-1:0] tick_cnt;
        logic [TICK_W-1:0] gate_last;
        logic              per_cnt;
        logic              div;
        logic              done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  accept;
    logic  is_period;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clr_o      = 1'b0;
        inc_o      = 1'b0;
        accept     = en_i && start_i && (ctl_q.state == ST_IDLE);
        is_period  = !sel_hf_i && !freq_mode_i;

        case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    clr_o           = !integrate_i;
                    ctl_d.mode      = sel_hf_i  ? MD_HF_FREQ :
                                      freq_mode_i ? MD_LF_FREQ : MD_LF_PERIOD;
                    ctl_d.two_per   = two_period_i;
                    ctl_d.tick_cnt  = '0;
                    ctl_d.gate_last = TICK_W'(gate_ms(gate_sel_i) * TICKS_PER_MS - 1);
                    ctl_d.per_cnt   = 1'b0;
                    ctl_d.div       = 1'b0;
                    ctl_d.state     = is_period ? ST_ARM : ST_MEAS;
                end
            end
            ST_ARM: begin
                if (lf_rise_i) ctl_d.state = ST_MEAS;
            end
            ST_MEAS: begin
                if (ctl_q.mode == MD_LF_PERIOD) begin
                    inc_o = ref_tick_i;
                    if (lf_rise_i) begin
                        if (ctl_q.per_cnt == ctl_q.two_per) begin
                            ctl_d.state = ST_IDLE;
                            ctl_d.done  = 1'b1;
                        end else begin
                            ctl_d.per_cnt = 1'b1;
                        end
                    end
                end else begin
                    if (ctl_q.mode == MD_HF_FREQ) begin
                        inc_o = hf_rise_i & ~ctl_q.div;
                        if (hf_rise_i) ctl_d.div = ~ctl_q.div;
                    end else begin
                        inc_o = lf_rise_i;
                    end
                    if (ref_tick_i) begin
                        if (ctl_q.tick_cnt == ctl_q.gate_last) begin
                            ctl_d.state = ST_IDLE;
                            ctl_d.done  = 1'b1;
                        end else begin
                            ctl_d.tick_cnt = ctl_q.tick_cnt + 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.mode  <= MD_HF_FREQ;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q.state != ST_IDLE);
    assign done_o = ctl_q.done;

endmodule

// File: rtl/sigmeter_accum.sv
module sigmeter_accum #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic             en_i,
    input  logic             level_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             sdo_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic [CNT_W-1:0] sh;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d.cnt = '0;
            acc_d.ovf = 1'b0;
        end else if (inc_i) begin
            if (&acc_q.cnt) acc_d.ovf = 1'b1;
            else            acc_d.cnt = acc_q.cnt + 1'b1;
        end
        if (load_i)       acc_d.sh = acc_q.cnt;
        else if (shift_i) acc_d.sh = {acc_q.sh[CNT_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign count_o = acc_q.cnt;
    assign ovf_o   = acc_q.ovf;
    assign sdo_o   = en_i ? acc_q.sh[CNT_W-1] : level_i;

endmodule

// File: rtl/sigmeter.sv
module sigmeter #(
    parameter int CNT_W        = 20,
    parameter int TICKS_PER_MS = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hf_in,
    input  logic             lf_in,
    input  logic             ref_tick,
    input  logic             meter_en,
    input  logic             sel_hf,
    input  logic             freq_mode,
    input  logic             two_period,
    input  logic             integrate,
    input  logic [1:0]       gate_sel,
    input  logic             start,
    input  logic             shift_step,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output logic             busy,
    output logic             done,
    output logic             sdo
);

    localparam int NUM_PINS = 2;
    localparam int PIN_LF   = 0;
    localparam int PIN_HF   = 1;

    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] pin_rise;
    logic                clr;
    logic                inc;
    logic                level_sel;

    sigmeter_sync #(.NUM(NUM_PINS)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   ({hf_in, lf_in}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    sigmeter_ctrl #(.TICKS_PER_MS(TICKS_PER_MS)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .en_i         (meter_en),
        .sel_hf_i     (sel_hf),
        .freq_mode_i  (freq_mode),
        .two_period_i (two_period),
        .integrate_i  (integrate),
        .gate_sel_i   (gate_sel),
        .hf_rise_i    (pin_rise[PIN_HF]),
        .lf_rise_i    (pin_rise[PIN_LF]),
        .ref_tick_i   (ref_tick),
        .busy_o       (busy),
        .done_o       (done),
        .clr_o        (clr),
        .inc_o        (inc)
    );

    assign level_sel = sel_hf ? pin_lvl[PIN_HF] : pin_lvl[PIN_LF];

    sigmeter_accum #(.CNT_W(CNT_W)) i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .inc_i   (inc),
        .load_i  (done),
        .shift_i (shift_step),
        .en_i    (meter_en),
        .level_i (level_sel),
        .count_o (count),
        .ovf_o   (overflow),
        .sdo_o   (sdo)
    );

endmodule

// File: rtl/sigmeter_chk.sv
module sigmeter_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             meter_en,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] count,
    input logic             overflow
);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r8_overflow_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (count == {CNT_W{1'b1}}));

    a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!meter_en && !busy) |=> !busy);

    a_r6_idle_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && meter_en)) |=> (busy || $stable(count)));

endmodule

bind sigmeter sigmeter_chk #(.CNT_W(CNT_W)) i_sigmeter_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .meter_en (meter_en),
    .busy     (busy),
    .done     (done),
    .count    (count),
    .overflow (overflow)
);

// File: tb/test_sigmeter.sv
`timescale 1ns/1ps
module test_sigmeter;

    localparam int CW  = 12;
    localparam int TPM = 16;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hf_in = 1'b0, lf_in = 1'b0, ref_tick = 1'b0;
    logic          meter_en = 1'b1, sel_hf = 1'b0, freq_mode = 1'b1;
    logic          two_period = 1'b0, integrate = 1'b0;
    logic [1:0]    gate_sel = 2'd0;
    logic          start = 1'b0, shift_step = 1'b0;
    logic [CW-1:0] count;
    logic          overflow, busy, done, sdo;

    int checks = 0;
    int errors = 0;
    int busy_ticks = 0;
    logic [1:0] tdiv = 2'd0;

    always #4 clk = ~clk;

    sigmeter #(.CNT_W(CW), .TICKS_PER_MS(TPM)) i_sigmeter (
        .clk(clk), .rst_n(rst_n), .hf_in(hf_in), .lf_in(lf_in),
        .ref_tick(ref_tick), .meter_en(meter_en), .sel_hf(sel_hf),
        .freq_mode(freq_mode), .two_period(two_period), .integrate(integrate),
        .gate_sel(gate_sel), .start(start), .shift_step(shift_step),
        .count(count), .overflow(overflow), .busy(busy), .done(done), .sdo(sdo)
    );

    // reference tick every 4 clocks; count ticks the design consumes while busy
    always @(negedge clk) begin
        if (busy && tdiv == 2'd3) busy_ticks <= busy_ticks + 1;
        ref_tick <= (tdiv == 2'd3);
        tdiv     <= tdiv + 2'd1;
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gms(input logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 8;
            2'd2: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic start_meas(input bit s_hf, input bit fm, input bit two,
                              input bit integ, input logic [1:0] gs);
        @(negedge clk);
        sel_hf = s_hf; freq_mode = fm; two_period = two; integrate = integ;
        gate_sel = gs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulses(input bit on_hf, input int n);
        for (int i = 0; i < n; i++) begin
            if (on_hf) hf_in = 1'b1; else lf_in = 1'b1;
            repeat (3) @(negedge clk);
            if (on_hf) hf_in = 1'b0; else lf_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 30000) begin
            @(negedge clk);
            t++;
        end
        chk(req, int'(done), 1, "done pulse seen");
        chk("R7", int'(busy), 0, "busy low with done");
    endtask

    task automatic read_serial(input int exp);
        logic [CW-1:0] v;
        @(negedge clk);
        chk("R7", int'(done), 0, "done lasts one clock");
        v[CW-1] = sdo;
        for (int i = CW - 2; i >= 0; i--) begin
            shift_step = 1'b1;
            @(negedge clk);
            shift_step = 1'b0;
            v[i] = sdo;
        end
        chk("R9", int'(v), exp, "serial word");
        shift_step = 1'b1;
        @(negedge clk);
        shift_step = 1'b0;
        chk("R9", int'(sdo), 0, "zero after LSB");
    endtask

    task automatic freq_case(input bit on_hf, input logic [1:0] gs, input int n,
                             input bit integ, input int prev, output int res);
        int t0, exp;
        t0 = busy_ticks;
        start_meas(on_hf, 1'b1, 1'b0, integ, gs);
        repeat (2) @(negedge clk);
        pulses(on_hf, n);
        wait_done(on_hf ? "R2" : "R3");
        exp = sat((integ ? prev : 0) + (on_hf ? (n + 1) / 2 : n));
        chk(on_hf ? "R2" : "R3", int'(count), exp, "frequency count");
        chk("R4", busy_ticks - t0, gms(gs) * TPM, "gate ticks");
        res = int'(count);
        read_serial(exp);
    endtask

    task automatic period_case(input int k, input bit two, input bit integ,
                               input int prev, output int res);
        int np, exp;
        np = two ? 2 : 1;
        start_meas(1'b0, 1'b0, two, integ, 2'd0);
        repeat (3) @(negedge clk);
        for (int i = 0; i <= np; i++) begin
            lf_in = 1'b1;
            repeat (2) @(negedge clk);
            lf_in = 1'b0;
            if (i < np) repeat (4 * k - 2) @(negedge clk);
        end
        wait_done("R5");
        exp = sat((integ ? prev : 0) + k * np);
        chk("R5", int'(count), exp, "period ticks");
        res = int'(count);
        read_serial(exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual busy=%0d expected finished run", busy);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r, mode, n, k;
        logic [1:0] gs;
        bit two;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(count), 0, "count");
        chk("R1", int'(busy), 0, "busy");
        chk("R1", int'(done), 0, "done");
        chk("R1", int'(overflow), 0, "overflow");
        chk("R1", int'(sdo), 0, "sdo");

        // directed frequency cases, both inputs, odd and even edge counts
        freq_case(1'b1, 2'd0, 7, 1'b0, 0, r);
        freq_case(1'b1, 2'd1, 10, 1'b0, 0, r);
        freq_case(1'b0, 2'd2, 13, 1'b0, 0, r);
        // R6 integrate adds to previous
        freq_case(1'b0, 2'd0, 5, 1'b1, r, r);
        chk("R6", r, 18, "integrated total");
        freq_case(1'b1, 2'd3, 1, 1'b0, 0, r);

        // R5 period windows of one and two periods
        period_case(9, 1'b0, 1'b0, 0, r);
        period_case(6, 1'b1, 1'b0, 0, r);

        // R7 start during busy is ignored
        begin
            int t0;
            t0 = busy_ticks;
            start_meas(1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
            pulses(1'b0, 4);
            start_meas(1'b1, 1'b0, 1'b0, 1'b0, 2'd3);
            pulses(1'b0, 3);
            wait_done("R7");
            chk("R7", int'(count), 7, "count after ignored restart");
            chk("R7", busy_ticks - t0, 4 * TPM, "gate not restarted");
        end

        // R8 saturation in a long period window
        period_case(4200, 1'b0, 1'b0, 0, r);
        chk("R8", int'(overflow), 1, "overflow set");
        freq_case(1'b0, 2'd0, 5, 1'b1, r, r);
        chk("R8", int'(overflow), 1, "overflow held by integrate");
        start_meas(1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
        chk("R6", int'(count), 0, "cleared at start");
        chk("R8", int'(overflow), 0, "overflow cleared");
        wait_done("R6");

        // R10 meter disabled
        @(negedge clk);
        meter_en = 1'b0; sel_hf = 1'b1; hf_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", int'(sdo), 1, "hf level");
        hf_in = 1'b0;
        sel_hf = 1'b0; lf_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", int'(sdo), 1, "lf level");
        lf_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", int'(sdo), 0, "lf low");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10", int'(busy), 0, "start ignored");
        meter_en = 1'b1;

        // random mix
        for (int it = 0; it < 10; it++) begin
            mode = int'($urandom % 4);
            gs   = 2'($urandom % 4);
            n    = 1 + int'($urandom % 30);
            k    = 5 + int'($urandom % 36);
            two  = 1'($urandom % 2);
            case (mode)
                0: freq_case(1'b1, gs, n, 1'b0, 0, r);
                1: freq_case(1'b0, gs, n, 1'b0, 0, r);
                default: period_case(k, two, 1'b0, 0, r);
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule